// File: doc/BRIEF.md
# SPI Paged Register Access Front End

This block is an SPI slave that turns a stream of 16-bit serial words into register accesses on a small paged register file. Each access starts with a command word that names a direction, a page and a register offset. The word after a write command carries the write data. The word after a read command is a dummy word, and the read data is shifted back to the host during that word. While the parser waits for a command, a word of all zeros continues a read burst: it reads at the saved page and offset, and every read moves the offset on by one.

Three pages share one strobe-style register-file port: a read-only data page, a control page and an audio page. The front end handles every case the pages do not. It supplies all-ones for pages that do not exist and for registers a page reports as absent. It drops writes to the data page. It keeps one control slot for itself, and writing an exact key value to that slot issues a single-cycle soft reset. SPI runs in mode 0, and SCLK and MOSI are sampled in the system clock domain.

Top module: `spi_paged_regif`

## Requirements
- R1: Bits are taken MSB first on rising SCLK while CS_n is low, 16 to a word. When CS_n goes high, any partial word is discarded and the parser goes back to expecting a command.
- R2: In a command word, bit 15 = 1 means read, bits 14:11 are the page, bits 10:5 are the offset, and bits 4:0 are ignored.
- R3: A write command followed by one data word produces exactly one write strobe to that page and offset with that data. The parser then expects a command again.
- R4: A read command reads the addressed register and shifts the value out MSB first during the next word. After every read the saved offset advances by one, wrapping from 63 to 0.
- R5: An all-zero word received while a command is expected reads at the saved page and offset. The data appears during the following word.
- R6: Writes to page 0 (data page) produce no strobe and leave its contents unchanged.
- R7: Reads of pages 3 to 15, or of a register whose hit flag is low, return 0xFFFF. Writes to pages 3 to 15 produce no strobe.
- R8: Writing 0xBB00 to page 1 offset 4 gives a one-cycle soft_reset pulse. Any other value written there does nothing. That slot is never forwarded to the pages and reads as 0xFFFF.
- R9: A nonzero word in the dummy slot of a read pulses overrun_err and is not written anywhere. A zero dummy word raises no error.
- R10: MISO is low when CS_n is high and during any word that carries no read data.
- R11: After reset, MISO is low, no strobe or pulse is active, a command is expected, and the saved pointer is page 0 offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_sclk | input | 1 | SPI serial clock, sampled by clk |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| pg_rd_en | output | NUM_PAGES | One-hot read strobe per page |
| pg_wr_en | output | NUM_PAGES | One-hot write strobe per page |
| pg_addr | output | 6 | Register offset within the page |
| pg_wdata | output | 16 | Write data |
| pg_rdata | input | 16*NUM_PAGES | Read data, page p in bits 16p+15:16p |
| pg_hit | input | NUM_PAGES | Page reports the addressed register exists |
| soft_reset | output | 1 | One-cycle soft reset pulse |
| overrun_err | output | 1 | One-cycle pulse for a write word during a read |

## Verification
A parser stuck in the wrong state shows up within one word. A data word is then taken as a command, so a write strobe goes missing or MISO returns the wrong value in the next slot. A pointer that does not advance, or advances when it should not, is caught on the second word of a zero-word burst and at the 63-to-0 wrap. A fault in page routing shows up on the very access it affects. It appears as a stray strobe count, a changed data-page value, a missing 0xFFFF, or a soft_reset or overrun pulse that is missing or doubled.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;
  localparam int WORD_W   = 16;
  localparam int PAGE_W   = 4;
  localparam int OFF_W    = 6;
  localparam int RD_BIT   = 15;
  localparam int PAGE_LSB = 11;
  localparam int OFF_LSB  = 5;
  localparam int DATA_PG  = 0;
  localparam int CTRL_PG  = 1;
  localparam int KEY_OFF  = 4;
  localparam logic [WORD_W-1:0] FILL_WORD = '1;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [PAGE_W-1:0] page_t;
  typedef logic [OFF_W-1:0]  off_t;

  typedef enum logic [1:0] {PS_CMD, PS_WDATA, PS_RDUMMY} parse_st_e;

  function automatic logic cmd_is_read(input word_t w);
    return w[RD_BIT];
  endfunction

  function automatic page_t cmd_page(input word_t w);
    return w[PAGE_LSB +: PAGE_W];
  endfunction

  function automatic off_t cmd_offset(input word_t w);
    return w[OFF_LSB +: OFF_W];
  endfunction

  function automatic off_t step_offset(input off_t o);
    return o + off_t'(1);
  endfunction

  function automatic logic is_key_slot(input page_t p, input off_t o);
    return (p == page_t'(CTRL_PG)) && (o == off_t'(KEY_OFF));
  endfunction
endpackage

// File: rtl/spi_word_shifter.sv
module spi_word_shifter
  import spi_regif_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  spi_cs_n,
  input  logic  spi_sclk,
  input  logic  spi_mosi,
  input  logic  tx_load,
  input  word_t tx_data,
  output logic  word_valid,
  output word_t word_q,
  output logic  spi_miso
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  logic             sclk_q;
  logic [CNT_W-1:0] bit_cnt;
  word_t            rx_sh;
  word_t            tx_q;

  wire sclk_rise = ~spi_cs_n & spi_sclk & ~sclk_q;
  wire sclk_fall = ~spi_cs_n & ~spi_sclk & sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q     <= 1'b0;
      bit_cnt    <= '0;
      rx_sh      <= '0;
      tx_q       <= '0;
      word_valid <= 1'b0;
      word_q     <= '0;
    end else begin
      sclk_q     <= spi_sclk;
      word_valid <= 1'b0;
      if (spi_cs_n) begin
        bit_cnt <= '0;
        rx_sh   <= '0;
        tx_q    <= '0;
      end else begin
        if (sclk_rise) begin
          rx_sh   <= {rx_sh[WORD_W-2:0], spi_mosi};
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == LAST_BIT) begin
            word_valid <= 1'b1;
            word_q     <= {rx_sh[WORD_W-2:0], spi_mosi};
          end
        end
        if (tx_load)
          tx_q <= tx_data;
        else if (sclk_fall && bit_cnt != '0)
          tx_q <= {tx_q[WORD_W-2:0], 1'b0};
      end
    end
  end

  assign spi_miso = tx_q[WORD_W-1] & ~spi_cs_n;

  // R1: a deselected bus leaves no partial word behind
  assert_idle_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |=> (bit_cnt == '0) && !word_valid);
  // R10: shift register is empty while deselected
  assert_idle_tx_R10: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |=> (tx_q == '0));
endmodule

// File: rtl/spi_cmd_parser.sv
module spi_cmd_parser
  import spi_regif_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  abort,
  input  logic  word_valid,
  input  word_t word_q,
  input  word_t rd_data,
  output logic  acc_rd,
  output logic  acc_wr,
  output page_t acc_page,
  output off_t  acc_off,
  output word_t acc_wdata,
  output logic  tx_load,
  output word_t tx_data,
  output logic  overrun_err
);
  parse_st_e st_q, st_nxt;
  page_t     ptr_page;
  off_t      ptr_off;

  wire zero_word = (word_q == '0);

  always_comb begin
    acc_rd   = 1'b0;
    acc_wr   = 1'b0;
    acc_page = ptr_page;
    acc_off  = ptr_off;
    st_nxt   = st_q;
    if (word_valid) begin
      unique case (st_q)
        PS_CMD: begin
          if (zero_word) begin
            acc_rd = 1'b1;
          end else if (cmd_is_read(word_q)) begin
            acc_rd   = 1'b1;
            acc_page = cmd_page(word_q);
            acc_off  = cmd_offset(word_q);
            st_nxt   = PS_RDUMMY;
          end else begin
            st_nxt = PS_WDATA;
          end
        end
        PS_WDATA: begin
          acc_wr = 1'b1;
          st_nxt = PS_CMD;
        end
        default: st_nxt = PS_CMD;
      endcase
    end
  end

  assign acc_wdata = word_q;
  assign tx_load   = word_valid;
  assign tx_data   = acc_rd ? rd_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= PS_CMD;
      ptr_page    <= '0;
      ptr_off     <= '0;
      overrun_err <= 1'b0;
    end else begin
      st_q        <= abort ? PS_CMD : st_nxt;
      overrun_err <= word_valid && (st_q == PS_RDUMMY) && !zero_word;
      if (acc_rd) begin
        ptr_page <= acc_page;
        ptr_off  <= step_offset(acc_off);
      end else if (word_valid && st_q == PS_CMD) begin
        ptr_page <= cmd_page(word_q);
        ptr_off  <= cmd_offset(word_q);
      end
    end
  end

  // R4: every read moves the saved offset one past the register read
  assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd |=> (ptr_off == off_t'($past(acc_off) + 1'b1)));
  // R9: the dummy slot of a read never becomes a write
  assert_overrun_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && st_q == PS_RDUMMY) |-> !acc_wr);
  // R1: deselect always lands in the command state
  assert_abort_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (st_q == PS_CMD));
endmodule

// File: rtl/spi_page_router.sv
module spi_page_router
  import spi_regif_pkg::*;
#(
  parameter int    NUM_PAGES = 3,
  parameter word_t RESET_KEY = 16'hBB00
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        acc_rd,
  input  logic                        acc_wr,
  input  page_t                       acc_page,
  input  off_t                        acc_off,
  input  word_t                       acc_wdata,
  input  logic [NUM_PAGES*WORD_W-1:0] pg_rdata,
  input  logic [NUM_PAGES-1:0]        pg_hit,
  output logic [NUM_PAGES-1:0]        pg_rd_en,
  output logic [NUM_PAGES-1:0]        pg_wr_en,
  output off_t                        pg_addr,
  output word_t                       pg_wdata,
  output word_t                       rd_data,
  output logic                        soft_reset
);
  wire key_slot = is_key_slot(acc_page, acc_off);

  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
    wire sel = (acc_page == page_t'(p)) && !key_slot;
    assign pg_rd_en[p] = acc_rd && sel;
    if (p == DATA_PG) begin : g_ro
      assign pg_wr_en[p] = 1'b0;
    end else begin : g_rw
      assign pg_wr_en[p] = acc_wr && sel;
    end
  end

  always_comb begin
    rd_data = FILL_WORD;
    for (int p = 0; p < NUM_PAGES; p++)
      if (acc_page == page_t'(p) && pg_hit[p] && !key_slot)
        rd_data = pg_rdata[p*WORD_W +: WORD_W];
  end

  assign pg_addr  = acc_off;
  assign pg_wdata = acc_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) soft_reset <= 1'b0;
    else        soft_reset <= acc_wr && key_slot && (acc_wdata == RESET_KEY);
  end

  // R3: at most one page strobe of one kind per cycle
  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pg_rd_en, pg_wr_en}));
  // R8: soft reset only follows an exact key write
  assert_key_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_reset |-> $past(acc_wr && key_slot && acc_wdata == RESET_KEY));
  // R8: soft reset lasts a single cycle
  assert_key_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_reset |=> !soft_reset);
endmodule

// File: rtl/spi_paged_regif.sv
module spi_paged_regif
  import spi_regif_pkg::*;
#(
  parameter int    NUM_PAGES = 3,
  parameter word_t RESET_KEY = 16'hBB00
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        spi_cs_n,
  input  logic                        spi_sclk,
  input  logic                        spi_mosi,
  output logic                        spi_miso,
  output logic [NUM_PAGES-1:0]        pg_rd_en,
  output logic [NUM_PAGES-1:0]        pg_wr_en,
  output logic [5:0]                  pg_addr,
  output logic [15:0]                 pg_wdata,
  input  logic [NUM_PAGES*16-1:0]     pg_rdata,
  input  logic [NUM_PAGES-1:0]        pg_hit,
  output logic                        soft_reset,
  output logic                        overrun_err
);
  logic  word_valid, tx_load, acc_rd, acc_wr;
  word_t word_q, tx_data, rd_data, acc_wdata;
  page_t acc_page;
  off_t  acc_off;

  spi_word_shifter u_shift (
    .clk, .rst_n, .spi_cs_n, .spi_sclk, .spi_mosi,
    .tx_load, .tx_data, .word_valid, .word_q, .spi_miso
  );

  spi_cmd_parser u_parse (
    .clk, .rst_n, .abort(spi_cs_n), .word_valid, .word_q, .rd_data,
    .acc_rd, .acc_wr, .acc_page, .acc_off, .acc_wdata,
    .tx_load, .tx_data, .overrun_err
  );

  spi_page_router #(.NUM_PAGES(NUM_PAGES), .RESET_KEY(RESET_KEY)) u_route (
    .clk, .rst_n, .acc_rd, .acc_wr, .acc_page, .acc_off, .acc_wdata,
    .pg_rdata, .pg_hit, .pg_rd_en, .pg_wr_en, .pg_addr, .pg_wdata,
    .rd_data, .soft_reset
  );

  // R9: an overrun pulse is never accompanied by a page write
  assert_overrun_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_err |-> (pg_wr_en == '0));
endmodule

// File: tb/spi_paged_regif_bench.sv
module spi_paged_regif_bench;
  localparam int NP   = 3;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic miso, soft_reset, overrun_err;
  logic [NP-1:0] pg_rd_en, pg_wr_en, pg_hit;
  logic [5:0] pg_addr;
  logic [15:0] pg_wdata;
  logic [NP*16-1:0] pg_rdata;

  always #2 clk = ~clk;

  spi_paged_regif u_spi_paged_regif (
    .clk, .rst_n, .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_mosi(mosi),
    .spi_miso(miso), .pg_rd_en, .pg_wr_en, .pg_addr, .pg_wdata,
    .pg_rdata, .pg_hit, .soft_reset, .overrun_err
  );

  logic [15:0] mem [0:2][0:63];
  int wr_cnt, sr_cnt, ov_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < 64; a++) begin
        mem[0][a] <= 16'h0A00 + 16'(a);
        mem[1][a] <= 16'h1100 + 16'(a);
        mem[2][a] <= 16'h2200 + 16'(a);
      end
      wr_cnt <= 0; sr_cnt <= 0; ov_cnt <= 0;
    end else begin
      for (int p = 0; p < NP; p++)
        if (pg_wr_en[p]) mem[p][pg_addr] <= pg_wdata;
      if (|pg_wr_en) wr_cnt <= wr_cnt + 1;
      if (soft_reset) sr_cnt <= sr_cnt + 1;
      if (overrun_err) ov_cnt <= ov_cnt + 1;
    end
  end

  assign pg_rdata = {mem[2][pg_addr], mem[1][pg_addr], mem[0][pg_addr]};
  assign pg_hit   = {pg_addr < 6'd30, pg_addr < 6'd6, pg_addr < 6'd12};

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic xfer(input logic [15:0] tx, input int nbits, output logic [15:0] rx);
    rx = '0;
    for (int i = 15; i > 15 - nbits; i--) begin
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
  endtask

  task automatic sel;
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic desel;
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // {command, data word, expected MISO during data word}
  localparam logic [47:0] VEC [14] = '{
    {16'h10A0, 16'h1234, 16'h0000},  // R3 write page2 off5
    {16'h90A0, 16'h0000, 16'h1234},  // R4 read back
    {16'h90BF, 16'h0000, 16'h1234},  // R2 low bits ignored
    {16'h8060, 16'h0000, 16'h0A03},  // R4 data page read
    {16'h0060, 16'hFFFF, 16'h0000},  // R6 data page write dropped
    {16'h8060, 16'h0000, 16'h0A03},  // R6 unchanged
    {16'h8840, 16'h0000, 16'h1102},  // R4 control page read
    {16'h9800, 16'h0000, 16'hFFFF},  // R7 page 3
    {16'h9500, 16'h0000, 16'hFFFF},  // R7 unmapped offset
    {16'h0880, 16'hBB00, 16'h0000},  // R8 key write
    {16'h8880, 16'h0000, 16'hFFFF},  // R8 key slot reads all-ones
    {16'h0820, 16'hBEEF, 16'h0000},  // R3 control write
    {16'h8820, 16'h0000, 16'hBEEF},  // R3 readback
    {16'h2820, 16'h5555, 16'h0000}   // R7 page 5 write dropped
  };

  initial begin
    logic [15:0] r0, r1, r2, r3;
    int w0, s0, o0;
    repeat (5) @(negedge clk);
    // R11 reset state
    chk("R11 miso", miso, 0);
    chk("R11 strobes", {pg_rd_en, pg_wr_en, soft_reset, overrun_err}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R5 zero words continue a read from the reset pointer, R4 increment
    sel; xfer(16'h0, 16, r0); xfer(16'h0, 16, r1); xfer(16'h0, 16, r2); desel;
    chk("R10 first slot", r0, 0);
    chk("R5 continued read off0", r1, 16'h0A00);
    chk("R4 continued read off1", r2, 16'h0A01);
    chk("R10 idle miso", miso, 0);

    w0 = wr_cnt; s0 = sr_cnt; o0 = ov_cnt;
    foreach (VEC[k]) begin
      sel;
      xfer(VEC[k][47:32], 16, r0);
      xfer(VEC[k][31:16], 16, r1);
      desel;
      chk($sformatf("R10 row %0d command slot", k), r0, 0);
      chk($sformatf("R2 R3 R4 R6 R7 R8 row %0d", k), r1, VEC[k][15:0]);
    end
    chk("R6 R7 R8 forwarded writes", wr_cnt - w0, 2);
    chk("R8 soft reset pulses", sr_cnt - s0, 1);
    chk("R9 no overrun in table", ov_cnt - o0, 0);
    chk("R6 data page memory", mem[0][3], 16'h0A03);

    // R4 R5 burst after a read command
    sel; xfer(16'h90A0, 16, r0); xfer(16'h0, 16, r1);
    xfer(16'h0, 16, r2); xfer(16'h0, 16, r3); desel;
    chk("R4 burst first", r1, 16'h1234);
    chk("R5 burst no data slot", r2, 0);
    chk("R5 burst next", r3, 16'h2206);

    // R4 offset wrap 63 -> 0
    sel; xfer(16'h97E0, 16, r0); xfer(16'h0, 16, r1);
    xfer(16'h0, 16, r2); xfer(16'h0, 16, r3); desel;
    chk("R7 off63 unmapped", r1, 16'hFFFF);
    chk("R4 wrap to off0", r3, 16'h2200);

    // R9 overrun
    w0 = wr_cnt; o0 = ov_cnt;
    sel; xfer(16'h8820, 16, r0); xfer(16'h00FF, 16, r1); desel;
    chk("R9 read data", r1, 16'hBEEF);
    chk("R9 overrun pulse", ov_cnt - o0, 1);
    chk("R9 no write", wr_cnt - w0, 0);
    sel; xfer(16'h8820, 16, r0); xfer(16'h0, 16, r1); desel;
    chk("R9 zero dummy silent", ov_cnt - o0, 1);

    // R1 deselect after a write command returns to command state
    w0 = wr_cnt;
    sel; xfer(16'h0840, 16, r0); desel;
    sel; xfer(16'h8840, 16, r0); xfer(16'h0, 16, r1); desel;
    chk("R1 abort then read", r1, 16'h1102);
    chk("R1 abort no write", wr_cnt - w0, 0);

    // R1 partial word discarded
    sel; xfer(16'h0820, 8, r0); desel;
    sel; xfer(16'h90A0, 16, r0); xfer(16'h0, 16, r1); desel;
    chk("R1 partial discarded", r1, 16'h1234);
    chk("R1 partial no write", wr_cnt - w0, 0);

    // R8 wrong key ignored
    s0 = sr_cnt;
    sel; xfer(16'h0880, 16, r0); xfer(16'hBB01, 16, r1); desel;
    chk("R8 wrong key no pulse", sr_cnt - s0, 0);
    chk("R8 key slot not forwarded", wr_cnt - w0, 0);
    chk("R10 miso deselected", miso, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog got timeout exp completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule